// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block keeps the volatile 6-bit setting of a digitally controlled potentiometer. It drives a one-hot enable for the 64 tap switches of the resistor ladder. The setting can change in four ways:

- a direct write from the host;
- a parallel transfer of a stored data register selected elsewhere;
- single steps up or down;
- a recall of stored register zero once power is stable.

The serial framing logic in front of it turns commands into one-cycle strobes. The analog array behind it consumes the tap enables.

The setting is volatile. After power-up it takes the value of stored register zero through the recall request, not the value it held before power was lost. The tap enables are registered and updated on the same edge as the position. This keeps the switch drive free of decode glitches, so there is never an instant with no tap or two taps closed. Write protection of the stored registers does not concern this block: every update path is always open.

Top module: `wiper_position_reg`

## Requirements
- R1: While reset is low and on the first cycle after it, the position reads 0 and only tap enable bit 0 is set.
- R2: At every clock edge exactly one tap enable bit is set, and its index equals the position. Position 0x00 drives bit 0, the low end of the ladder. Position 0x3F drives bit 63, the high end.
- R3: A recall request sets the position to the boot value on the next cycle.
- R4: A direct write strobe or a parallel transfer strobe sets the position to the load value on the next cycle.
- R5: A lone up step adds one to the position, and a lone down step subtracts one.
- R6: An up step at 0x3F leaves 0x3F, and a down step at 0x00 leaves 0x00. The position never wraps.
- R7: When requests coincide, a recall wins over a load, and a load wins over a step.
- R8: Up and down steps in the same cycle, with no recall or load, leave the position unchanged.
- R9: With no request, the position and the tap enables hold their value.
- R10: Any update shows on both the position and the tap enables in the cycle right after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recallReq | input | 1 | Power-up recall strobe, highest priority |
| bootVal | input | 6 | Contents of stored register zero |
| hostWr | input | 1 | Direct host write strobe |
| xferLd | input | 1 | Parallel transfer strobe from a stored register |
| loadVal | input | 6 | Value for a write or transfer |
| stepUp | input | 1 | Step toward the high end |
| stepDn | input | 1 | Step toward the low end |
| posOut | output | 6 | Current wiper position |
| tapEn | output | 64 | One-hot tap switch enables |

## Verification
The assertions take every strobe as a level sampled once per clock. They expect the boot and load values to be stable while their strobe is high, and they place no limit on how requests may coincide.

The stimulus changes inputs only on the falling clock edge, one operation per cycle. It deliberately includes overlapping recall, load and step requests, up and down steps together, and steps against both end stops. This covers each priority and saturation case. A full walk up the ladder checks every tap index against the position.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Arbitrated update command from control to datapath
  typedef struct packed {
    logic takeBoot;
    logic takeLoad;
    logic goUp;
    logic goDown;
  } wiperCmd_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic      recallReq,
  input  logic      hostWr,
  input  logic      xferLd,
  input  logic      stepUp,
  input  logic      stepDn,
  output wiperCmd_t cmd
);
  logic anyLoad;
  logic stepOk;

  always_comb begin
    anyLoad      = hostWr | xferLd;
    // a step only when no higher request and exactly one direction
    stepOk       = ~recallReq & ~anyLoad & (stepUp ^ stepDn);
    cmd.takeBoot = recallReq;
    cmd.takeLoad = ~recallReq & anyLoad;
    cmd.goUp     = stepOk & stepUp;
    cmd.goDown   = stepOk & stepDn;
  end
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int TAP_N = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  wiperCmd_t        cmd,
  input  logic [POS_W-1:0] bootVal,
  input  logic [POS_W-1:0] loadVal,
  output logic [POS_W-1:0] posQ,
  output logic [TAP_N-1:0] tapQ
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] posNext;
  logic [TAP_N-1:0] tapNext;

  always_comb begin
    posNext = posQ;
    if (cmd.takeBoot)                   posNext = bootVal;
    else if (cmd.takeLoad)              posNext = loadVal;
    else if (cmd.goUp && posQ != POS_MAX)   posNext = posQ + 1'b1;
    else if (cmd.goDown && posQ != POS_MIN) posNext = posQ - 1'b1;
  end

  // decode the next position so the taps flip on the same edge as posQ
  for (genvar g = 0; g < TAP_N; g++) begin : gTap
    assign tapNext[g] = (posNext == POS_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
      tapQ <= TAP_N'(1);
    end else begin
      posQ <= posNext;
      tapQ <= tapNext;
    end
  end
endmodule

// File: rtl/wiper_position_reg.sv
module wiper_position_reg
  import wiper_pkg::*;
#(
  parameter int POS_W = 6,
  localparam int TAP_N = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recallReq,
  input  logic [POS_W-1:0] bootVal,
  input  logic             hostWr,
  input  logic             xferLd,
  input  logic [POS_W-1:0] loadVal,
  input  logic             stepUp,
  input  logic             stepDn,
  output logic [POS_W-1:0] posOut,
  output logic [TAP_N-1:0] tapEn
);
  wiperCmd_t cmd;

  wiper_ctrl i_ctrl (
    .recallReq(recallReq),
    .hostWr   (hostWr),
    .xferLd   (xferLd),
    .stepUp   (stepUp),
    .stepDn   (stepDn),
    .cmd      (cmd)
  );

  wiper_datapath #(.POS_W(POS_W), .TAP_N(TAP_N)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .bootVal(bootVal),
    .loadVal(loadVal),
    .posQ   (posOut),
    .tapQ   (tapEn)
  );
endmodule

// File: rtl/wiper_position_chk.sv
module wiper_position_chk #(
  parameter int POS_W = 6,
  parameter int TAP_N = 1 << POS_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             recallReq,
  input logic [POS_W-1:0] bootVal,
  input logic             hostWr,
  input logic             xferLd,
  input logic [POS_W-1:0] loadVal,
  input logic             stepUp,
  input logic             stepDn,
  input logic [POS_W-1:0] posOut,
  input logic [TAP_N-1:0] tapEn
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  logic anyLd;
  assign anyLd = hostWr | xferLd;

  a_r2_one_tap: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapEn) == 1);
  a_r2_tap_index: assert property (@(posedge clk) disable iff (!rstN)
    tapEn[posOut] == 1'b1);
  a_r3_recall: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> posOut == $past(bootVal));
  a_r4_r7_load: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && anyLd) |=> posOut == $past(loadVal));
  a_r5_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && !anyLd && stepUp && !stepDn && posOut != POS_MAX)
      |=> posOut == POS_W'($past(posOut) + 1'b1));
  a_r6_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && !anyLd && stepUp && posOut == POS_MAX) |=> posOut == POS_MAX);
  a_r6_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && !anyLd && stepDn && posOut == '0) |=> posOut == '0);
  a_r8_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && !anyLd && stepUp && stepDn) |=> $stable(posOut));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!recallReq && !anyLd && !stepUp && !stepDn) |=> ($stable(posOut) && $stable(tapEn)));
endmodule

bind wiper_position_reg wiper_position_chk #(.POS_W(POS_W), .TAP_N(TAP_N)) i_chk (
  .clk(clk), .rstN(rstN), .recallReq(recallReq), .bootVal(bootVal),
  .hostWr(hostWr), .xferLd(xferLd), .loadVal(loadVal),
  .stepUp(stepUp), .stepDn(stepDn), .posOut(posOut), .tapEn(tapEn)
);

// File: tb/test_wiper_position_reg.sv
`timescale 1ns/1ps
module test_wiper_position_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        recallReq = 1'b0;
  logic [5:0]  bootVal = '0;
  logic        hostWr = 1'b0;
  logic        xferLd = 1'b0;
  logic [5:0]  loadVal = '0;
  logic        stepUp = 1'b0;
  logic        stepDn = 1'b0;
  logic [5:0]  posOut;
  logic [63:0] tapEn;

  int checks = 0;
  int failures = 0;
  int cycleCnt = 0;
  bit done = 1'b0;
  logic [5:0] model = '0;

  int         qDue[$];
  logic [5:0] qExp[$];
  string      qTag[$];

  always #2 clk = ~clk;

  wiper_position_reg i_wiper_position_reg (
    .clk(clk), .rstN(rstN), .recallReq(recallReq), .bootVal(bootVal),
    .hostWr(hostWr), .xferLd(xferLd), .loadVal(loadVal),
    .stepUp(stepUp), .stepDn(stepDn), .posOut(posOut), .tapEn(tapEn)
  );

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic compare(input string tag, input logic [5:0] exp);
    checks++;
    if (posOut !== exp || tapEn !== (64'd1 << exp)) begin
      failures++;
      $display("FAIL %s: pos=%h tap=%h expected pos=%h tap=%h",
               tag, posOut, tapEn, exp, 64'd1 << exp);
    end
  endtask

  // monitor: pops items whose result edge has passed
  always @(negedge clk) begin
    while (qDue.size() > 0 && qDue[0] <= cycleCnt) begin
      void'(qDue.pop_front());
      compare(qTag.pop_front(), qExp.pop_front());
    end
  end

  // driver: one operation per cycle, pushes expected result
  task automatic op(input logic rec, input logic [5:0] boot, input logic wr,
                    input logic xf, input logic [5:0] ld, input logic up,
                    input logic dn, input string tag);
    @(negedge clk);
    recallReq = rec; bootVal = boot; hostWr = wr; xferLd = xf;
    loadVal = ld; stepUp = up; stepDn = dn;
    if (rec)                  model = boot;
    else if (wr || xf)        model = ld;
    else if (up && !dn)       model = (model == 6'h3F) ? model : model + 6'd1;
    else if (dn && !up)       model = (model == 6'h00) ? model : model - 6'd1;
    qDue.push_back(cycleCnt + 1);
    qExp.push_back(model);
    qTag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 6'h15, 1'b0, 1'b0, 6'h2B, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 6'h00);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 6'h00);

    op(1'b1, 6'h2A, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, "R3 recall");
    idle("R9 hold after recall");
    op(1'b0, 6'h00, 1'b1, 1'b0, 6'h05, 1'b0, 1'b0, "R4 host write R10");
    op(1'b0, 6'h00, 1'b0, 1'b1, 6'h3F, 1'b0, 1'b0, "R4 transfer R2 high end");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, "R6 up at top");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, "R6 up at top again");
    for (int i = 0; i < 3; i++)
      op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, "R5 down step");
    op(1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b0, 1'b0, "R4 write zero R2 low end");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, "R6 down at bottom");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, "R5 up step");
    op(1'b1, 6'h11, 1'b1, 1'b1, 6'h22, 1'b1, 1'b0, "R7 recall beats load and step");
    op(1'b0, 6'h00, 1'b0, 1'b1, 6'h30, 1'b0, 1'b1, "R7 load beats step");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1, "R8 up and down cancel");
    idle("R9 hold");
    idle("R9 hold second");
    op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, "R5 down from mid");
    op(1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b0, 1'b0, "R2 walk start");
    for (int i = 0; i < 63; i++)
      op(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, "R2 walk step");
    op(1'b1, 6'h07, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, "R7 recall beats step");
    idle("R9 final hold");
    idle("R9 final hold end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycleCnt > 5000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycleCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule